// File: doc/BRIEF.md
# Factorial Compute Unit with Status

A small register-mapped compute peripheral. Software writes an operand n into the factorial register and the unit computes n! one multiply per clock. Every product is truncated to 32 bits. While the unit works, a busy flag in the status register is set. Software can poll that flag, or it can set an interrupt-enable bit and wait for a one-cycle completion strobe that an interrupt aggregator collects. When the run ends, the result replaces the contents of the factorial register. The unit also has a constant identification word and a scratch register that stores the complement of what is written to it.

Register accesses arrive on a valid/ready request channel, and read data leaves on a valid/ready response channel. Back-pressure works as follows. The unit holds one response at most. A request is accepted only when the response slot is empty or is being drained in the same cycle, so `req_ready` is low exactly while a response waits with `rsp_ready` low. A response stays valid, and its data stays unchanged, until `rsp_ready` is sampled high. Writes produce no response.

Top module: `fact_unit`

## Requirements
- R1: A read of offset 0x00 returns 0x010000ED, and a write to that offset changes nothing.
- R2: A write to offset 0x04 stores the bitwise complement of the written data, and a read of 0x04 returns the stored word. The stored word is 0 after reset.
- R3: A write to offset 0x08 while the unit is idle loads the operand and starts a run. A status read accepted in the next cycle shows bit 0 (busy) set.
- R4: A run with operand n leaves n!·mod 2^32 at offset 0x08, with 0 and 1 both giving 1. Busy clears max(n,1) cycles after the load. The offset 0x08 word reads 0 after reset.
- R5: A write to offset 0x08 while busy is ignored: the running computation and its result are unchanged.
- R6: The status word at 0x20 has bit 0 = busy and bit 7 = interrupt enable, and all other bits read 0. A write copies data bit 7 into the enable bit and leaves busy untouched. The status word is 0 after reset.
- R7: When a run ends with the enable bit set, `irq_done` pulses high for exactly one cycle, in the cycle after busy clears. With the enable bit clear, it stays low.
- R8: `req_ready` is low only while a response is pending and `rsp_ready` is low. A pending response keeps `rsp_rdata` stable. Each accepted read yields exactly one response and a write yields none.
- R9: A read of any offset other than 0x00, 0x04, 0x08 or 0x20 returns 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_rdata | output | 32 | Read data |
| irq_done | output | 1 | One-cycle completion strobe |

## Verification
The factorial path is tried with the following operands:
- 0 and 1 separate the empty-product start value from a run that skips its single iteration.
- 5, 10 and 12 confirm the multiply order and the iteration count.
- 13 is the first operand whose product exceeds 32 bits, so it exposes the truncation.

A second write issued while a run is in progress shows whether operands are locked out. Runs with the enable bit set and clear tell the interrupt strobe apart from the plain completion. Reads with a stalling response consumer test the hold-and-block rules of the response channel.

// File: rtl/fact_pkg.sv
`timescale 1ns/1ps
package fact_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_ID   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_SCR  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_FACT = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h20;

  localparam logic [DATA_W-1:0] ID_WORD = 32'h010000ED;

  localparam int unsigned STAT_BUSY = 0;
  localparam int unsigned STAT_IEN  = 7;

  typedef enum logic [2:0] {
    SEL_ID,
    SEL_SCR,
    SEL_FACT,
    SEL_STAT,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/fact_decode.sv
`timescale 1ns/1ps
module fact_decode
  import fact_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic [AW-1:0] addr,
  output reg_sel_e      sel
);
  always_comb begin
    unique case (addr)
      OFS_ID:   sel = SEL_ID;
      OFS_SCR:  sel = SEL_SCR;
      OFS_FACT: sel = SEL_FACT;
      OFS_STAT: sel = SEL_STAT;
      default:  sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/fact_engine.sv
`timescale 1ns/1ps
module fact_engine #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] operand,
  output logic         busy,
  output logic         finish,
  output logic [W-1:0] value
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] prod_q;
  logic [W-1:0] down_q;
  logic         busy_q;
  logic         last_step;

  // down counter at 0 or 1: no further factor to apply
  assign last_step = (down_q[W-1:1] == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod_q <= '0;
      down_q <= '0;
      busy_q <= 1'b0;
    end else if (load && !busy_q) begin
      prod_q <= ONE;
      down_q <= operand;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (last_step) begin
        busy_q <= 1'b0;
      end else begin
        prod_q <= prod_q * down_q;
        down_q <= down_q - ONE;
      end
    end
  end

  assign busy   = busy_q;
  assign finish = busy_q && last_step;
  assign value  = prod_q;
endmodule

// File: rtl/fact_ctrl_regs.sv
`timescale 1ns/1ps
module fact_ctrl_regs
  import fact_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_fire,
  input  reg_sel_e     sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] scratch,
  output logic         ien
);
  logic [W-1:0] scratch_q;
  logic         ien_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scratch_q <= '0;
      ien_q     <= 1'b0;
    end else if (wr_fire) begin
      if (sel == SEL_SCR)  scratch_q <= ~wdata;
      if (sel == SEL_STAT) ien_q     <= wdata[STAT_IEN];
    end
  end

  assign scratch = scratch_q;
  assign ien     = ien_q;
endmodule

// File: rtl/fact_unit.sv
`timescale 1ns/1ps
module fact_unit
  import fact_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata,
  output logic          irq_done
);
  reg_sel_e      sel;
  logic          req_fire, wr_fire, rd_fire;
  logic          busy, finish, ien;
  logic [DW-1:0] fact_word, scratch, stat_word, rd_mux;
  logic          rsp_valid_q, irq_q;
  logic [DW-1:0] rsp_data_q;

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign req_fire  = req_valid && req_ready;
  assign wr_fire   = req_fire && req_write;
  assign rd_fire   = req_fire && !req_write;

  fact_decode #(.AW(AW)) u_dec (
    .addr (req_addr),
    .sel  (sel)
  );

  fact_engine #(.W(DW)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (wr_fire && (sel == SEL_FACT)),
    .operand (req_wdata),
    .busy    (busy),
    .finish  (finish),
    .value   (fact_word)
  );

  fact_ctrl_regs #(.W(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fire (wr_fire),
    .sel     (sel),
    .wdata   (req_wdata),
    .scratch (scratch),
    .ien     (ien)
  );

  always_comb begin
    stat_word            = '0;
    stat_word[STAT_BUSY] = busy;
    stat_word[STAT_IEN]  = ien;
  end

  always_comb begin
    unique case (sel)
      SEL_ID:   rd_mux = ID_WORD;
      SEL_SCR:  rd_mux = scratch;
      SEL_FACT: rd_mux = fact_word;
      SEL_STAT: rd_mux = stat_word;
      default:  rd_mux = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      irq_q       <= 1'b0;
    end else begin
      if (rd_fire) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= rd_mux;
      end else if (rsp_ready) begin
        rsp_valid_q <= 1'b0;
      end
      irq_q <= finish && ien;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_data_q;
  assign irq_done  = irq_q;
endmodule

// File: rtl/fact_unit_chk.sv
`timescale 1ns/1ps
module fact_unit_chk
  import fact_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_rdata,
  input logic          irq_done,
  input logic          busy,
  input logic          ien
);
  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && req_addr == OFS_FACT && !busy) |=> busy);

  p_irq_after_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> (!busy && $past(busy)));

  p_irq_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> $past(ien));

  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |=> !irq_done);

  p_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  p_rsp_from_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready && !req_write));
endmodule

bind fact_unit fact_unit_chk #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/fact_unit_tb.sv
`timescale 1ns/1ps
module fact_unit_tb;
  import fact_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        irq_done;

  always #2.5 clk = ~clk;

  fact_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .irq_done(irq_done)
  );

  int          n_checks = 0;
  int          n_fail = 0;
  int          irq_count = 0;
  bit          stall_mode = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] fact_ref(int unsigned n);
    logic [31:0] r = 32'd1;
    for (int unsigned k = n; k > 1; k--) r = r * k;
    return r;
  endfunction

  // driver: issue one request, push expectation for reads
  task automatic send(bit wr, logic [7:0] a, logic [31:0] d,
                      logic [31:0] exp, string tag);
    @(negedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) begin @(negedge clk); #1; end
    if (!wr) begin exp_q.push_back(exp); tag_q.push_back(tag); end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor: response consumer and scoreboard
  initial begin
    int          cyc = 0;
    bit          held = 1'b0;
    logic [31:0] held_val = '0;
    bit          irq_prev = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      rsp_ready = stall_mode ? (cyc % 3 == 0) : 1'b1;
      if (held && rsp_valid) check("R8 held response stable", rsp_rdata, held_val);
      held = 1'b0;
      if (rst_n && rsp_valid && !rsp_ready) begin held = 1'b1; held_val = rsp_rdata; end
      if (rst_n && rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          check("R8 unexpected response", 32'd1, 32'd0);
        end else begin
          check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
        end
      end
      if (rst_n && irq_done) begin
        irq_count++;
        if (irq_prev) check("R7 pulse width", 32'd2, 32'd1);
      end
      irq_prev = irq_done;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic run_fact(int unsigned n, bit en);
    int base;
    drain();
    base = irq_count;
    send(1'b1, OFS_FACT, n, 0, "");
    send(1'b0, OFS_STAT, 0, en ? 32'h81 : 32'h01, "R3 busy after load");
    repeat (n + 6) @(negedge clk);
    send(1'b0, OFS_FACT, 0, fact_ref(n), "R4 factorial result");
    send(1'b0, OFS_STAT, 0, en ? 32'h80 : 32'h00, "R4 busy cleared");
    drain();
    check("R7 interrupt count", irq_count - base, en ? 1 : 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R8 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R7 reset irq_done", {31'd0, irq_done}, 32'd0);

    send(1'b0, OFS_ID,   0, ID_WORD, "R1 id word");
    send(1'b0, OFS_STAT, 0, 32'h0,   "R6 status reset");
    send(1'b0, OFS_FACT, 0, 32'h0,   "R4 fact reset");
    send(1'b0, OFS_SCR,  0, 32'h0,   "R2 scratch reset");

    send(1'b1, OFS_SCR, 32'h12345678, 0, "");
    send(1'b0, OFS_SCR, 0, 32'hEDCBA987, "R2 complement");
    send(1'b1, OFS_SCR, 32'h0, 0, "");
    send(1'b0, OFS_SCR, 0, 32'hFFFFFFFF, "R2 complement zero");

    send(1'b1, OFS_ID, 32'h0, 0, "");
    send(1'b0, OFS_ID, 0, ID_WORD, "R1 id after write");
    send(1'b0, 8'h10, 0, 32'hFFFFFFFF, "R9 unmapped 0x10");
    send(1'b0, 8'h0C, 0, 32'hFFFFFFFF, "R9 unmapped 0x0C");
    send(1'b0, 8'hFC, 0, 32'hFFFFFFFF, "R9 unmapped 0xFC");

    send(1'b1, OFS_STAT, 32'hFFFFFF7F, 0, "");
    send(1'b0, OFS_STAT, 0, 32'h0,  "R6 only bit 7 written");
    send(1'b1, OFS_STAT, 32'h00000080, 0, "");
    send(1'b0, OFS_STAT, 0, 32'h80, "R6 enable set");
    send(1'b1, OFS_STAT, 32'h0, 0, "");
    send(1'b0, OFS_STAT, 0, 32'h0,  "R6 enable cleared");

    run_fact(0, 1'b0);
    run_fact(1, 1'b0);
    run_fact(5, 1'b0);
    run_fact(12, 1'b0);
    send(1'b1, OFS_STAT, 32'h80, 0, "");
    run_fact(10, 1'b1);
    run_fact(13, 1'b1);
    send(1'b1, OFS_STAT, 32'h0, 0, "");

    // R5: second operand during a run is dropped; status write keeps busy (R6)
    drain();
    send(1'b1, OFS_FACT, 32'd6, 0, "");
    send(1'b1, OFS_FACT, 32'd3, 0, "");
    send(1'b1, OFS_STAT, 32'h1, 0, "");
    send(1'b0, OFS_STAT, 0, 32'h01, "R6 busy kept by status write");
    repeat (12) @(negedge clk);
    send(1'b0, OFS_FACT, 0, 32'd720, "R5 locked operand");
    drain();

    // R8: stalled consumer
    stall_mode = 1'b1;
    send(1'b0, OFS_ID,  0, ID_WORD, "R8 stalled id");
    send(1'b0, OFS_SCR, 0, 32'hFFFFFFFF, "R8 stalled scratch");
    send(1'b0, OFS_FACT, 0, 32'd720, "R8 stalled fact");
    send(1'b0, 8'h44, 0, 32'hFFFFFFFF, "R8 stalled unmapped");
    drain();
    stall_mode = 1'b0;
    drain();

    summary();
    $finish;
  end
endmodule